// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit turns a 32-bit segment offset into a 32-bit linear address for every memory access that the core issues. It holds six segment registers. Each register caches a descriptor with a linear base, a byte limit and a permission attribute, together with a live flag that is set when the selector loaded with it is not null. Every access reaches the unit with a class (fetch, pop, push, load, store). The class picks the segment, unless the request names one directly through an override. The unit adds the base to the offset modulo 2^32, then checks the last byte of the access against the limit and the access kind against the attribute.

There is no path that skips translation. To get flat operation, software loads a segment with base 0 and limit 0xFFFFFFFF. A side port loads segment registers, one per cycle, with a selector and its descriptor. Requests enter through a valid/ready handshake. The result comes back one cycle later through a second valid/ready pair, carrying either a linear address or a fault code.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset all six segment registers are null, `rsp_valid` is low, and any access returns fault code 1 (NULL).
- R2: With no override, class 0 (FETCH) uses segment 0 (code), classes 1 (POP) and 2 (PUSH) use segment 2 (stack), and classes 3 (LOAD), 4 (STORE) and 5 to 7 (treated as LOAD) use segment 1 (data). Segments 3, 4 and 5 are the three extra segments.
- R3: When `req_ovr_en` is high, every class other than FETCH uses `req_ovr_seg`. FETCH ignores the override. Override values 6 and 7 name no register and give fault code 1.
- R4: On a good access `rsp_lin` equals base plus offset modulo 2^32. For example, base 0x10000000 with offset 0xF0100000 gives 0x00100000.
- R5: An access of `req_size`+1 bytes faults with code 2 (LIMIT) when offset + `req_size` exceeds the limit. The sum is taken without wrap, so an access that runs past 0xFFFFFFFF also faults.
- R6: Attribute bit 0 means readable, bit 1 writable, bit 2 executable. These give fault code 3 (TYPE): PUSH or STORE to a segment without bit 1, FETCH from a segment without bit 2, and POP or LOAD from a segment with bit 2 set and bit 0 clear.
- R7: A load whose selector has index bits [15:3] equal to zero and table bit [2] equal to zero makes the register null, whatever ring bits [1:0] hold. A zero index with table bit 1 is not null.
- R8: A request accepted at a clock edge produces `rsp_valid` at the next edge. While `rsp_valid` is high and `rsp_ready` is low, the response holds steady and `req_ready` is low.
- R9: A faulted response carries `rsp_lin` = 0. When more than one check fails, the code reported follows the order NULL over LIMIT over TYPE.
- R10: A request accepted in the same cycle as a load of its segment is translated with the descriptor held before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load a segment register this cycle |
| ld_seg | input | 3 | Segment register to load (0..5) |
| ld_sel | input | 16 | Selector: index [15:3], table [2], ring [1:0] |
| ld_base | input | 32 | Descriptor linear base |
| ld_limit | input | 32 | Descriptor limit (last valid offset) |
| ld_attr | input | 3 | Attribute: [0] readable, [1] writable, [2] executable |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_class | input | 3 | Access class: 0 FETCH, 1 POP, 2 PUSH, 3 LOAD, 4 STORE |
| req_ovr_en | input | 1 | Use the named segment instead of the implicit one |
| req_ovr_seg | input | 3 | Segment named by the override |
| req_off | input | 32 | Offset within the segment |
| req_size | input | 2 | Access size in bytes minus one |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_lin | output | 32 | Linear address, or 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 NULL, 2 LIMIT, 3 TYPE |

## Verification
A corrupted segment register does not show up on its own. It appears only on the next access that selects that register: as a wrong `rsp_lin`, as a fault that should not be there, or as a missing one, one cycle after the request is accepted. The bench therefore loads each register with its own base, limit and attribute, and reaches every register through both implicit and override selection, so that a fault in the decoder, in one entry or in the checks is visible at the ports on the next response. Tests with backpressure and with a load in the same cycle as a request exercise the output register and the ordering of register updates against translation.

// File: rtl/seg_xlt_pkg.sv
package seg_xlt_pkg;
  localparam int ADDR_W  = 32;
  localparam int SEL_W   = 16;
  localparam int ATTR_W  = 3;
  localparam int NUM_SEG = 6;
  localparam int SEG_W   = 3;

  localparam int ATTR_RD = 0;
  localparam int ATTR_WR = 1;
  localparam int ATTR_EX = 2;

  typedef enum logic [2:0] {
    CLS_FETCH = 3'd0,
    CLS_POP   = 3'd1,
    CLS_PUSH  = 3'd2,
    CLS_LOAD  = 3'd3,
    CLS_STORE = 3'd4
  } acc_class_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_NULL  = 2'd1,
    FLT_LIMIT = 2'd2,
    FLT_TYPE  = 2'd3
  } fault_e;

  localparam logic [SEG_W-1:0] SEG_CODE  = 3'd0;
  localparam logic [SEG_W-1:0] SEG_DATA  = 3'd1;
  localparam logic [SEG_W-1:0] SEG_STACK = 3'd2;

  typedef struct packed {
    logic              live;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic [ATTR_W-1:0] attr;
  } seg_desc_t;

  // null when index and table bits are all zero; ring bits are masked off
  function automatic logic sel_is_null(input logic [SEL_W-1:0] sel);
    return (sel & 16'hFFFC) == 16'h0000;
  endfunction
endpackage

// File: rtl/seg_reg_file.sv
module seg_reg_file
  import seg_xlt_pkg::*;
#(
  parameter int NSEG = NUM_SEG,
  parameter int IW   = SEG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [IW-1:0]    ld_idx,
  input  logic [SEL_W-1:0] ld_sel,
  input  logic [ADDR_W-1:0] ld_base,
  input  logic [ADDR_W-1:0] ld_limit,
  input  logic [ATTR_W-1:0] ld_attr,
  input  logic [IW-1:0]    rd_idx,
  output seg_desc_t        rd_desc
);
  seg_desc_t ent_q [NSEG];
  seg_desc_t ld_desc;

  always_comb begin
    ld_desc.live  = !sel_is_null(ld_sel);
    ld_desc.base  = ld_base;
    ld_desc.limit = ld_limit;
    ld_desc.attr  = ld_attr;
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_ent
    logic      we;
    seg_desc_t ent_d;

    always_comb begin
      we    = ld_en && (ld_idx == IW'(i));
      ent_d = we ? ld_desc : ent_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[i] <= '0;
      else if (we) ent_q[i] <= ent_d;
    end

    // R7: null selector load leaves the entry null
    a_r7_null_load: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && ld_idx == IW'(i) && (ld_sel[SEL_W-1:2] == '0)) |=> !ent_q[i].live);
    // R7: zero index from the local table is not null
    a_r7_local_live: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && ld_idx == IW'(i) && (ld_sel[SEL_W-1:3] == '0) && ld_sel[2]) |=> ent_q[i].live);
  end

  always_comb begin
    rd_desc = '0;
    for (int k = 0; k < NSEG; k++)
      if (rd_idx == IW'(k)) rd_desc = ent_q[k];
  end
endmodule

// File: rtl/seg_pick.sv
module seg_pick
  import seg_xlt_pkg::*;
#(
  parameter int IW = SEG_W
) (
  input  logic [2:0]    cls,
  input  logic          ovr_en,
  input  logic [IW-1:0] ovr_idx,
  output logic [IW-1:0] idx,
  output logic          is_fetch,
  output logic          is_write
);
  always_comb begin
    is_fetch = (cls == CLS_FETCH);
    is_write = (cls == CLS_PUSH) || (cls == CLS_STORE);
    unique case (cls)
      CLS_FETCH:          idx = IW'(SEG_CODE);
      CLS_POP, CLS_PUSH:  idx = IW'(SEG_STACK);
      default:            idx = IW'(SEG_DATA);
    endcase
    if (ovr_en && !is_fetch) idx = ovr_idx;
  end
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlt_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  seg_desc_t     desc,
  input  logic [AW-1:0] off,
  input  logic [1:0]    size_m1,
  input  logic          is_fetch,
  input  logic          is_write,
  output logic [1:0]    code,
  output logic [AW-1:0] lin
);
  logic [AW:0] last_byte;
  logic        over, bad_type;

  always_comb begin
    last_byte = {1'b0, off} + {{(AW-1){1'b0}}, size_m1};
    over      = last_byte > {1'b0, desc.limit};
    if (is_fetch)      bad_type = !desc.attr[ATTR_EX];
    else if (is_write) bad_type = !desc.attr[ATTR_WR];
    else               bad_type = desc.attr[ATTR_EX] && !desc.attr[ATTR_RD];

    if (!desc.live)    code = FLT_NULL;
    else if (over)     code = FLT_LIMIT;
    else if (bad_type) code = FLT_TYPE;
    else               code = FLT_NONE;

    lin = (code == FLT_NONE) ? desc.base + off : '0;
  end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlt_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int NSEG = NUM_SEG,
  parameter int IW   = SEG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_seg,
  input  logic [15:0]   ld_sel,
  input  logic [AW-1:0] ld_base,
  input  logic [AW-1:0] ld_limit,
  input  logic [2:0]    ld_attr,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_class,
  input  logic          req_ovr_en,
  input  logic [IW-1:0] req_ovr_seg,
  input  logic [AW-1:0] req_off,
  input  logic [1:0]    req_size,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_lin,
  output logic [1:0]    rsp_fault
);
  logic [IW-1:0] sel_idx;
  logic          is_fetch, is_write;
  seg_desc_t     desc;
  logic [1:0]    chk_code;
  logic [AW-1:0] chk_lin;

  seg_pick #(.IW(IW)) u_pick (
    .cls(req_class), .ovr_en(req_ovr_en), .ovr_idx(req_ovr_seg),
    .idx(sel_idx), .is_fetch(is_fetch), .is_write(is_write)
  );

  seg_reg_file #(.NSEG(NSEG), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_seg), .ld_sel(ld_sel),
    .ld_base(ld_base), .ld_limit(ld_limit), .ld_attr(ld_attr),
    .rd_idx(sel_idx), .rd_desc(desc)
  );

  seg_check #(.AW(AW)) u_chk (
    .desc(desc), .off(req_off), .size_m1(req_size), .is_fetch(is_fetch),
    .is_write(is_write), .code(chk_code), .lin(chk_lin)
  );

  logic          accept, rsp_en;
  logic          vld_d;
  logic [AW-1:0] lin_d;
  logic [1:0]    flt_d;

  always_comb begin
    req_ready = !rsp_valid || rsp_ready;
    accept    = req_valid && req_ready;
    rsp_en    = accept || (rsp_valid && rsp_ready);
    vld_d     = accept;
    lin_d     = accept ? chk_lin  : rsp_lin;
    flt_d     = accept ? chk_code : rsp_fault;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_lin   <= '0;
      rsp_fault <= '0;
    end else if (rsp_en) begin
      rsp_valid <= vld_d;
      rsp_lin   <= lin_d;
      rsp_fault <= flt_d;
    end
  end

  // R8: accepted request answers on the next edge
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  // R8: stalled response holds and blocks new requests
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_lin) && $stable(rsp_fault)));
  // R9: faulted response carries no address
  a_r9_zero_lin: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_lin == '0));
  // R5: a passing access stays inside the limit of the register read
  a_r5_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && chk_code == FLT_NONE) |->
      (({1'b0, req_off} + {{(AW-1){1'b0}}, req_size}) <= {1'b0, desc.limit}));
  // R3: fetch always reads the code register
  a_r3_fetch_code: assert property (@(posedge clk) disable iff (!rst_n)
    (req_class == CLS_FETCH) |-> (sel_idx == IW'(SEG_CODE)));
endmodule

// File: tb/seg_xlate_unit_bench.sv
module seg_xlate_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_en;
  logic [2:0]  ld_seg;
  logic [15:0] ld_sel;
  logic [31:0] ld_base, ld_limit;
  logic [2:0]  ld_attr;
  logic        req_valid, req_ready;
  logic [2:0]  req_class;
  logic        req_ovr_en;
  logic [2:0]  req_ovr_seg;
  logic [31:0] req_off;
  logic [1:0]  req_size;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_lin;
  logic [1:0]  rsp_fault;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate_unit u_seg_xlate_unit (.*);

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] q_lin[$];
  logic [1:0]  q_code[$];
  string       q_tag[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: a transfer happens at the posedge following a negedge with valid&ready
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (q_lin.size() == 0) chk(1'b0, "R8 unexpected response", {30'd0, rsp_fault}, 32'd0);
      else begin
        logic [31:0] el; logic [1:0] ec; string et;
        el = q_lin.pop_front(); ec = q_code.pop_front(); et = q_tag.pop_front();
        chk(rsp_fault == ec, {et, " code"}, {30'd0, rsp_fault}, {30'd0, ec});
        chk(rsp_lin == el, {et, " lin"}, rsp_lin, el);
      end
    end
  end

  task automatic load(input logic [2:0] s, input logic [15:0] sel, input logic [31:0] b,
                      input logic [31:0] l, input logic [2:0] a);
    ld_en = 1; ld_seg = s; ld_sel = sel; ld_base = b; ld_limit = l; ld_attr = a;
    @(posedge clk); #1;
    ld_en = 0;
  endtask

  task automatic send(input logic [2:0] c, input bit oe, input logic [2:0] os,
                      input logic [31:0] off, input logic [1:0] sz,
                      input logic [31:0] el, input logic [1:0] ec, input string tag);
    req_valid = 1; req_class = c; req_ovr_en = oe; req_ovr_seg = os; req_off = off; req_size = sz;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    q_lin.push_back(el); q_code.push_back(ec); q_tag.push_back(tag);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic drain();
    int n = 0;
    while (q_lin.size() != 0 && n < 100) begin @(posedge clk); n++; end
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ld_en = 0; ld_seg = 0; ld_sel = 0; ld_base = 0; ld_limit = 0; ld_attr = 0;
    req_valid = 0; req_class = 0; req_ovr_en = 0; req_ovr_seg = 0; req_off = 0; req_size = 0;
    rsp_ready = 1;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    chk(rsp_valid == 0, "R1 rsp_valid after reset", {31'd0, rsp_valid}, 0);
    chk(req_ready == 1, "R1 req_ready after reset", {31'd0, req_ready}, 1);
    @(posedge clk); #1;
    send(3'd3, 0, 0, 32'h10, 0, 0, 2'd1, "R1 load before any segment");
    send(3'd0, 0, 0, 32'h0, 0, 0, 2'd1, "R1 fetch before any segment");

    load(0, 16'h0008, 32'h1000_0000, 32'hFFFF_FFFF, 3'b101);
    load(1, 16'h0010, 32'h0000_2000, 32'h0000_0FFF, 3'b011);
    load(2, 16'h0018, 32'h8000_0000, 32'h0000_FFFF, 3'b011);
    load(3, 16'h0020, 32'h0050_0000, 32'hFFFF_FFFF, 3'b001);
    load(4, 16'h0003, 32'h0000_4000, 32'hFFFF_FFFF, 3'b011);
    load(5, 16'h0004, 32'h0000_0100, 32'hFFFF_FFFF, 3'b011);

    send(3'd0, 0, 0, 32'hF010_0000, 0, 32'h0010_0000, 0, "R4 R2 fetch wraps to low linear");
    send(3'd3, 0, 0, 32'h100, 3, 32'h2100, 0, "R2 load uses data segment");
    send(3'd2, 0, 0, 32'h10, 3, 32'h8000_0010, 0, "R2 push uses stack segment");
    send(3'd1, 0, 0, 32'hFFFC, 3, 32'h8000_FFFC, 0, "R2 pop uses stack segment");
    send(3'd6, 0, 0, 32'h8, 0, 32'h2008, 0, "R2 spare class acts as load");
    send(3'd3, 0, 0, 32'hFFC, 3, 32'h2FFC, 0, "R5 last dword inside limit");
    send(3'd3, 0, 0, 32'hFFD, 3, 0, 2'd2, "R5 dword crosses limit");
    send(3'd1, 0, 0, 32'h1_0000, 0, 0, 2'd2, "R5 pop past stack limit");
    send(3'd3, 1, 5, 32'hFFFF_FFFF, 1, 0, 2'd2, "R5 access wraps past 2^32");
    send(3'd3, 1, 3, 32'h4, 0, 32'h0050_0004, 0, "R3 override load extra");
    send(3'd4, 1, 3, 32'h4, 0, 0, 2'd3, "R6 store to read-only");
    send(3'd0, 1, 3, 32'h20, 0, 32'h1000_0020, 0, "R3 fetch ignores override");
    send(3'd3, 1, 3'd6, 32'h0, 0, 0, 2'd1, "R3 override to missing register");
    send(3'd3, 1, 4, 32'h0, 0, 0, 2'd1, "R7 null selector with ring 3");
    send(3'd4, 1, 5, 32'h0, 0, 32'h0000_0100, 0, "R7 local index 0 is live");
    drain();

    load(0, 16'h0008, 32'h0, 32'hFFFF_FFFF, 3'b011);
    send(3'd0, 0, 0, 32'h40, 0, 0, 2'd3, "R6 fetch from non-executable");
    load(3, 16'h0020, 32'h0, 32'h0000_00FF, 3'b100);
    send(3'd3, 1, 3, 32'h10, 0, 0, 2'd3, "R6 read execute-only");
    send(3'd4, 1, 3, 32'h200, 0, 0, 2'd2, "R9 limit wins over type");
    load(4, 16'h0003, 32'h0, 32'h0, 3'b100);
    send(3'd4, 1, 4, 32'h200, 0, 0, 2'd1, "R9 null wins over limit and type");
    drain();

    // R8 backpressure
    rsp_ready = 0;
    send(3'd3, 0, 0, 32'h20, 0, 32'h2020, 0, "R8 stalled response");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(rsp_valid == 1, "R8 response held valid", {31'd0, rsp_valid}, 1);
      chk(rsp_lin == 32'h2020, "R8 response address held", rsp_lin, 32'h2020);
      chk(req_ready == 0, "R8 request blocked under stall", {31'd0, req_ready}, 0);
    end
    @(posedge clk); #1;
    rsp_ready = 1;
    drain();

    // R10 load and request in the same cycle
    ld_en = 1; ld_seg = 1; ld_sel = 16'h0010; ld_base = 32'h3000; ld_limit = 32'hFFF; ld_attr = 3'b011;
    req_valid = 1; req_class = 3'd3; req_ovr_en = 0; req_ovr_seg = 0; req_off = 32'h10; req_size = 0;
    @(negedge clk);
    chk(req_ready == 1, "R10 request accepted with load", {31'd0, req_ready}, 1);
    q_lin.push_back(32'h2010); q_code.push_back(0); q_tag.push_back("R10 uses descriptor before load");
    @(posedge clk); #1;
    ld_en = 0; req_valid = 0;
    send(3'd3, 0, 0, 32'h10, 0, 32'h3010, 0, "R10 next request sees new descriptor");

    load(1, 16'h0010, 32'h0, 32'hFFFF_FFFF, 3'b011);
    send(3'd4, 0, 0, 32'hDEAD_BEE0, 3, 32'hDEAD_BEE0, 0, "R4 flat segment is identity");
    drain();
    chk(q_lin.size() == 0, "R8 all responses returned", q_lin.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule